// File: doc/BRIEF.md
# Serial LED Shift-Out Engine

This block drives an external chain of serial-in parallel-out shift registers that hold LED or GPIO output levels. It sends a 17-bit output word one bit at a time on a serial data pin. Each bit is clocked by a divided shift clock. When the whole word has gone out, a latch strobe copies it to the parallel outputs of the chain. The word can come from two places:

- **Direct mode:** the host writes the word through the configuration port.
- **Flash mode:** the word is a 17-bit vector from a bank of waveform generators. The engine shifts it out again each time that vector differs from the word last sent.

The host configures the engine through a valid/ready write port. A write completes on a clock edge where both `cfg_valid` and `cfg_ready` are high. The host must hold the address and data stable until that edge. `cfg_ready` is low during the whole of a shift, so every write waits until the engine is idle. This wait is the busy lock-out: no new word, divisor, delay or mode can take effect while a word is in flight.

Top module: `sipo_shift_engine`

## Requirements
- R1: After reset the engine is idle: `busy`, `sclk`, `sdo` and `slatch` are low, `cfg_ready` is high, and `dly_eff` is 0. The divisor code and both mode bits reset to 0.
- R2: In direct mode, a write to address 0 shifts out bits [16:0] of the write data, most significant bit first. The external chain takes one bit on each rising edge of `sclk`, and `sdo` stays stable while `sclk` is high.
- R3: The divisor code (address 1, bits [1:0]) sets the bit period N = 4 << code system cycles, so the codes give 4, 8, 16 and 32. In each bit period `sclk` is high for N/2 cycles. A shift keeps `busy` high for 17·N + N/2 cycles.
- R4: With an effective delay d (address 2), `sclk` rises d+1 cycles after the start of its bit period. That is also d+1 cycles after `busy` rises.
- R5: The delay can never exceed N/2−1. A larger value written to the delay register is stored as N/2−1. Writing a new divisor clamps the stored delay to the new bound. `dly_eff` shows the stored value.
- R6: Mode bit 0 (address 3) selects the latch behaviour. When it is 0, one `slatch` pulse N/2 cycles long follows the last bit, with `sclk` low. When it is 1 (plain shift-register style), no strobe is sent.
- R7: `cfg_ready` is low whenever `busy` is high. A write held on the port while a shift runs is accepted after `busy` falls. The shift in flight keeps its divisor, delay and mode.
- R8: When mode bit 1 is set (flash mode), the idle engine shifts out the sampled `gen_vec` whenever it differs from the word last shifted. While the two are equal, no shift starts. An all-zero vector therefore produces no shift after zeros were last sent.
- R9: In flash mode a write to address 0 is accepted but starts no shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_valid | input | 1 | Configuration write request |
| cfg_ready | output | 1 | High when a write can be accepted (engine idle) |
| cfg_addr | input | 2 | 0 data word, 1 divisor code, 2 delay, 3 mode |
| cfg_wdata | input | 17 | Write data |
| gen_vec | input | 17 | Waveform generator levels used in flash mode |
| sdo | output | 1 | Serial data to the chain |
| sclk | output | 1 | Shift clock to the chain |
| slatch | output | 1 | Latch strobe to the chain |
| busy | output | 1 | Shift in progress |
| dly_eff | output | 4 | Stored (clamped) clock delay |

## Verification
The bench builds the engine with its default parameters: a 17-bit word, a 2-bit divisor code and a base divide of 4. With these values all four bit periods, from 4 to 32 cycles, can be timed cycle by cycle. The delay bound of N/2−1 can be hit from both sides. Stimulus includes a delay written above the bound and a divisor change that shrinks the bound under an existing delay. The flash-mode vectors cover the quiet all-zero case and shifts triggered by changes in both directions.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_LATCH} sh_state_e;
  localparam logic [1:0] ADR_DATA = 2'd0;
  localparam logic [1:0] ADR_DIV  = 2'd1;
  localparam logic [1:0] ADR_DLY  = 2'd2;
  localparam logic [1:0] ADR_MODE = 2'd3;
endpackage

// File: rtl/sipo_cfg_regs.sv
module sipo_cfg_regs
  import sipo_pkg::*;
#(
  parameter int WORD_W   = 17,
  parameter int CODE_W   = 2,
  parameter int BASE_DIV = 4,
  parameter int DLY_W    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic              wr_ready,
  input  logic [1:0]        wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              busy,
  output logic [CODE_W-1:0] div_code,
  output logic [DLY_W-1:0]  dly,
  output logic [1:0]        mode,
  output logic              dir_start,
  output logic [WORD_W-1:0] dir_word
);
  logic [CODE_W-1:0] div_q;
  logic [DLY_W-1:0]  dly_q;
  logic [1:0]        mode_q;
  logic              acc;

  function automatic int dly_lim(input logic [CODE_W-1:0] c);
    return ((BASE_DIV << c) / 2) - 1;
  endfunction

  function automatic logic [DLY_W-1:0] clamp(input int v, input logic [CODE_W-1:0] c);
    int lim;
    lim = dly_lim(c);
    return (v > lim) ? DLY_W'(lim) : DLY_W'(v);
  endfunction

  assign acc = wr_valid && wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      dly_q  <= '0;
      mode_q <= '0;
    end else if (acc) begin
      case (wr_addr)
        ADR_DIV: begin
          div_q <= wr_data[CODE_W-1:0];
          dly_q <= clamp(int'(dly_q), wr_data[CODE_W-1:0]);
        end
        ADR_DLY:  dly_q  <= clamp(int'(wr_data), div_q);
        ADR_MODE: mode_q <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  assign dir_start = acc && (wr_addr == ADR_DATA) && !mode_q[1];
  assign dir_word  = wr_data;
  assign div_code  = div_q;
  assign dly       = dly_q;
  assign mode      = mode_q;

  AST_DLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dly_q) <= dly_lim(div_q)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(div_q) && $stable(dly_q) && $stable(mode_q))); // R7
endmodule

// File: rtl/sipo_flash_trig.sv
module sipo_flash_trig #(
  parameter int WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              idle,
  input  logic              hold,
  input  logic [WORD_W-1:0] gen_in,
  input  logic              start_any,
  input  logic [WORD_W-1:0] start_word,
  output logic              fl_start,
  output logic [WORD_W-1:0] fl_word
);
  logic [WORD_W-1:0] gen_q;
  logic [WORD_W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q  <= '0;
      last_q <= '0;
    end else begin
      gen_q <= gen_in;
      if (start_any) last_q <= start_word;
    end
  end

  assign fl_start = en && idle && !hold && (gen_q != last_q);
  assign fl_word  = gen_q;
endmodule

// File: rtl/sipo_shifter.sv
module sipo_shifter
  import sipo_pkg::*;
#(
  parameter int WORD_W   = 17,
  parameter int CODE_W   = 2,
  parameter int BASE_DIV = 4,
  parameter int CNT_W    = 6,
  parameter int DLY_W    = 4,
  parameter int BIT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic [CODE_W-1:0] div_code,
  input  logic [DLY_W-1:0]  dly,
  input  logic              no_latch,
  output logic              sdo,
  output logic              sclk,
  output logic              slatch,
  output logic              busy
);
  sh_state_e         st_q;
  logic [CNT_W-1:0]  phase_q;
  logic [BIT_W-1:0]  bit_q;
  logic [WORD_W-1:0] sreg_q;
  logic              nolat_q;
  logic [CNT_W-1:0]  div_n, half_n, dly_n;

  assign div_n  = CNT_W'(BASE_DIV) << div_code;
  assign half_n = div_n >> 1;
  assign dly_n  = CNT_W'(dly);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      sreg_q  <= '0;
      nolat_q <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          st_q    <= ST_SHIFT;
          phase_q <= '0;
          bit_q   <= BIT_W'(WORD_W - 1);
          sreg_q  <= word;
          nolat_q <= no_latch;
        end
        ST_SHIFT: if (phase_q == div_n - 1'b1) begin
          phase_q <= '0;
          if (bit_q == '0) st_q <= ST_LATCH;
          else begin
            bit_q  <= bit_q - 1'b1;
            sreg_q <= sreg_q << 1;
          end
        end else phase_q <= phase_q + 1'b1;
        ST_LATCH: if (phase_q == half_n - 1'b1) begin
          st_q    <= ST_IDLE;
          phase_q <= '0;
        end else phase_q <= phase_q + 1'b1;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sdo    = (st_q == ST_SHIFT) ? sreg_q[WORD_W-1] : 1'b0;
  assign sclk   = (st_q == ST_SHIFT) && (phase_q > dly_n) && (phase_q <= dly_n + half_n);
  assign slatch = (st_q == ST_LATCH) && !nolat_q;
  assign busy   = (st_q != ST_IDLE);

  AST_SDO_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdo)); // R2
  AST_CLK_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (phase_q != '0)); // R4
  AST_LATCH_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    slatch |-> !sclk); // R6
  AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy); // R7
endmodule

// File: rtl/sipo_shift_engine.sv
module sipo_shift_engine #(
  parameter int WORD_W   = 17,
  parameter int CODE_W   = 2,
  parameter int BASE_DIV = 4,
  localparam int MAX_DIV = BASE_DIV << ((1 << CODE_W) - 1),
  localparam int DLY_W   = $clog2(MAX_DIV / 2),
  localparam int CNT_W   = $clog2(MAX_DIV) + 1,
  localparam int BIT_W   = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  output logic              cfg_ready,
  input  logic [1:0]        cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic [WORD_W-1:0] gen_vec,
  output logic              sdo,
  output logic              sclk,
  output logic              slatch,
  output logic              busy,
  output logic [DLY_W-1:0]  dly_eff
);
  logic [CODE_W-1:0] div_code;
  logic [DLY_W-1:0]  dly;
  logic [1:0]        mode;
  logic              dir_start, fl_start, start_any, acc;
  logic [WORD_W-1:0] dir_word, fl_word, start_word;

  assign cfg_ready  = !busy;
  assign acc        = cfg_valid && cfg_ready;
  assign start_any  = dir_start || fl_start;
  assign start_word = dir_start ? dir_word : fl_word;
  assign dly_eff    = dly;

  sipo_cfg_regs #(.WORD_W(WORD_W), .CODE_W(CODE_W), .BASE_DIV(BASE_DIV), .DLY_W(DLY_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_valid(cfg_valid), .wr_ready(cfg_ready),
    .wr_addr(cfg_addr), .wr_data(cfg_wdata), .busy(busy),
    .div_code(div_code), .dly(dly), .mode(mode),
    .dir_start(dir_start), .dir_word(dir_word)
  );

  sipo_flash_trig #(.WORD_W(WORD_W)) u_flash (
    .clk(clk), .rst_n(rst_n), .en(mode[1]), .idle(!busy), .hold(acc),
    .gen_in(gen_vec), .start_any(start_any), .start_word(start_word),
    .fl_start(fl_start), .fl_word(fl_word)
  );

  sipo_shifter #(.WORD_W(WORD_W), .CODE_W(CODE_W), .BASE_DIV(BASE_DIV),
                 .CNT_W(CNT_W), .DLY_W(DLY_W), .BIT_W(BIT_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .start(start_any), .word(start_word),
    .div_code(div_code), .dly(dly), .no_latch(mode[0]),
    .sdo(sdo), .sclk(sclk), .slatch(slatch), .busy(busy)
  );

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !(dir_start && fl_start)); // R9
endmodule

// File: tb/tb_sipo_shift_engine.sv
module tb_sipo_shift_engine;
  localparam int NV = 5;
  localparam int V_CODE[NV] = '{0, 1, 2, 3, 0};
  localparam int V_DLY[NV]  = '{0, 3, 7, 15, 9};
  localparam int V_M164[NV] = '{0, 0, 1, 0, 0};
  localparam logic [16:0] V_WORD[NV] = '{17'h1ABCD, 17'h00001, 17'h10000, 17'h15555, 17'h0F0F0};

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        cfg_valid = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [16:0] cfg_wdata = '0, gen_vec = '0;
  wire         cfg_ready, sdo, sclk, slatch, busy;
  wire [3:0]   dly_eff;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [16:0] m_word;
  int m_first, m_len, m_high, m_latch, m_rdy;

  sipo_shift_engine dut (.clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gen_vec(gen_vec), .sdo(sdo), .sclk(sclk),
    .slatch(slatch), .busy(busy), .dly_eff(dly_eff));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [1:0] a, input logic [16:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_valid = 1'b1;
    while (!cfg_ready) @(negedge clk);
    @(negedge clk);
    cfg_valid = 1'b0;
  endtask

  task automatic measure();
    logic prev = 1'b0, lprev = 1'b0;
    int idx = 0;
    m_word = '0; m_first = -1; m_high = 0; m_latch = 0; m_rdy = 0;
    while (busy && idx < 5000) begin
      if (sclk && !prev) begin
        m_word = {m_word[15:0], sdo};
        if (m_first < 0) m_first = idx;
      end
      if (sclk) m_high++;
      if (slatch && !lprev) m_latch++;
      if (cfg_ready) m_rdy++;
      prev = sclk; lprev = slatch;
      idx++;
      @(negedge clk);
    end
    m_len = idx;
  endtask

  task automatic wait_busy(input int lim, output int seen);
    int n = 0;
    while (!busy && n < lim) begin @(negedge clk); n++; end
    seen = busy;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL R7 watchdog actual=expired expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 0);
    check("R1 sclk", sclk, 0);
    check("R1 slatch", slatch, 0);
    check("R1 sdo", sdo, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", cfg_ready, 1);
    check("R1 dly_eff", dly_eff, 0);

    for (int i = 0; i < NV; i++) begin
      int n, half, ed;
      n = 4 << V_CODE[i]; half = n / 2;
      ed = (V_DLY[i] > half - 1) ? half - 1 : V_DLY[i];
      cfg_write(2'd1, 17'(V_CODE[i]));
      cfg_write(2'd2, 17'(V_DLY[i]));
      cfg_write(2'd3, 17'(V_M164[i]));
      check("R5 dly_eff", dly_eff, ed);
      cfg_write(2'd0, V_WORD[i]);
      measure();
      check("R2 word", int'(m_word), int'(V_WORD[i]));
      check("R3 busy length", m_len, 17 * n + half);
      check("R3 sclk high cycles", m_high, 17 * half);
      check("R4 first rise", m_first, ed + 1);
      check("R6 latch pulses", m_latch, V_M164[i] ? 0 : 1);
      check("R7 ready low while busy", m_rdy, 0);
    end

    // R5: divisor change clamps an existing delay
    cfg_write(2'd1, 17'd2);
    cfg_write(2'd2, 17'd7);
    check("R5 dly kept", dly_eff, 7);
    cfg_write(2'd1, 17'd0);
    check("R5 dly reclamped", dly_eff, 1);

    // R7: write held during a shift, accepted afterwards
    cfg_write(2'd2, 17'd0);
    cfg_write(2'd3, 17'd0);
    cfg_write(2'd0, 17'h0AAAA);
    cfg_addr = 2'd1; cfg_wdata = 17'd3; cfg_valid = 1'b1;
    measure();
    check("R7 ready low", m_rdy, 0);
    check("R7 old divisor held", m_len, 70);
    check("R7 word", int'(m_word), 17'h0AAAA);
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_write(2'd0, 17'h00F0F);
    measure();
    check("R7 held write applied", m_len, 560);

    // R8/R9: flash mode
    cfg_write(2'd1, 17'd0);
    cfg_write(2'd0, 17'h00000);
    measure();
    cfg_write(2'd3, 17'd2);
    repeat (40) @(negedge clk);
    check("R8 zero vector no shift", busy, 0);
    gen_vec = 17'h00101;
    wait_busy(40, seen);
    check("R8 change starts shift", seen, 1);
    measure();
    check("R8 flash word", int'(m_word), 17'h00101);
    wait_busy(40, seen);
    check("R8 equal vector no shift", seen, 0);
    cfg_write(2'd0, 17'h1FFFF);
    wait_busy(40, seen);
    check("R9 data write ignored", seen, 0);
    gen_vec = 17'h00000;
    wait_busy(40, seen);
    check("R8 return to zero shifts", seen, 1);
    measure();
    check("R8 zero word", int'(m_word), 0);
    check("R8 latch", m_latch, 1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule